// File: doc/BRIEF.md
# ATM Cell Transmit Scrambler

This block sits in the transmit path of a cell-based line interface and scrambles outgoing 53-byte ATM cells. Cells arrive one byte per clock on an 8-bit stream qualified by a valid strobe, with a start-of-cell strobe marking the first header byte. Each byte leaves the block one clock later, either unchanged, scrambled, or (for the header check byte) replaced by a freshly computed value.

Two scrambling schemes are offered, and each has its own enable input. The self-synchronizing scheme (polynomial x^43 + 1) scrambles only the 48 payload bytes and leaves all header bytes alone. The distributed-sample scheme (polynomial x^31 + x^28 + 1) scrambles every byte except the header check byte, and regenerates that check byte from the header bytes as they look after scrambling. The scheme is picked once per cell, on its start-of-cell byte. The self-synchronizing scheme wins when both enables are set. With neither enable set, cells pass through untouched.

Top module: `atm_cell_scrambler`

## Requirements
- R1: `out_valid` and `out_soc` repeat `in_valid` and `in_valid && in_soc` one clock later, and every accepted byte appears on `out_data` exactly one clock after it was presented.
- R2: The mode of a cell is fixed from `sss_en`/`dss_en` as sampled on the start-of-cell byte (`in_valid && in_soc`). Changes to either enable during the remaining bytes of that cell have no effect on them.
- R3: When neither enable was set at start of cell, all 53 bytes of the cell leave bit-exact.
- R4: In self-synchronizing mode, cell positions 0 to 4 (four header bytes plus the check byte) leave unchanged.
- R5: In self-synchronizing mode, positions 5 to 52 are scrambled MSB first: each output bit is the input bit XOR the scrambled bit sent 43 bit-times earlier.
- R6: The 43-bit self-synchronizing history is cleared to zero only by reset. It persists across cells, and it advances only on payload bytes of self-synchronizing cells.
- R7: In distributed-sample mode, positions 0 to 3 and 5 to 52 are XORed MSB first with a 31-bit generator. Per bit, the mask bit is the generator's top bit (bit 30), the feedback is bit 30 XOR bit 27, and the state shifts left taking the feedback into bit 0. The generator is all-ones after reset and steps 8 times on every byte of a distributed-sample cell, the check byte included.
- R8: In distributed-sample mode, position 4 is replaced by the CRC-8 (x^8 + x^2 + x + 1, initial value 0, MSB first) of the four scrambled header bytes, XORed with 0x55. The input byte at that position is discarded.
- R9: When both enables are set at start of cell, the cell is handled exactly as in self-synchronizing mode.
- R10: Bytes accepted after position 52 with no new start of cell, or before the first start of cell after reset, leave unchanged and advance no scrambler state. A start of cell in the middle of a cell restarts counting at position 0.
- R11: While reset (`rst_n` low, synchronous) is applied, `out_valid`, `out_soc` and `out_data` are 0.
- R12: `in_soc`, `in_data` and the enables are ignored while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte qualifier |
| in_soc | input | 1 | Marks cell position 0 when `in_valid` is high |
| in_data | input | 8 | Input cell byte |
| sss_en | input | 1 | Selects self-synchronizing mode at start of cell |
| dss_en | input | 1 | Selects distributed-sample mode at start of cell |
| out_valid | output | 1 | Output byte qualifier |
| out_soc | output | 1 | Marks output cell position 0 |
| out_data | output | 8 | Output cell byte |

## Verification
The hardest situation to reach from the ports is the self-synchronizing history carrying over across cells of other modes, pass-through stretches and idle gaps. A fault there shows only in payload bytes many cells later, and only once the history holds ones. The stimulus therefore runs long random chains of cells whose modes, gaps, truncations and trailing extra bytes are all drawn at random. Directed cells also flip the enables in mid-cell and set both at once. Each output byte is compared against a bench model that keeps its own history, generator and CRC.

// File: rtl/atm_scr_pkg.sv
// Shared types and mode resolution for the ATM cell transmit scrambler.
// Assumes a single clock domain; no state lives here.
package atm_scr_pkg;

    // Scrambling mode applied to one cell
    typedef enum logic [1:0] {
        MODE_BYP = 2'd0,
        MODE_SSS = 2'd1,
        MODE_DSS = 2'd2
    } scr_mode_t;

    // Region of the current byte inside the cell
    typedef enum logic [1:0] {
        REG_OUT = 2'd0,
        REG_HDR = 2'd1,
        REG_HEC = 2'd2,
        REG_PAY = 2'd3
    } cell_region_t;

    // Fixed priority: self-synchronizing over distributed-sample over bypass
    function automatic scr_mode_t resolve_mode(input logic sss_en, input logic dss_en);
        if (sss_en)      return MODE_SSS;
        else if (dss_en) return MODE_DSS;
        else             return MODE_BYP;
    endfunction

endpackage

// File: rtl/scr_cell_tracker.sv
// Tracks the position of each accepted byte within a cell and latches the
// scrambling mode on the start-of-cell byte.
// Assumes in_soc is only meaningful with in_valid; positions beyond the last
// byte are parked at CELL_BYTES until the next start of cell.
module scr_cell_tracker
    import atm_scr_pkg::*;
#(
    parameter int CELL_BYTES = 53,
    parameter int HDR_BYTES  = 4,
    localparam int PW        = $clog2(CELL_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_soc,
    input  logic          sss_en,
    input  logic          dss_en,
    output logic [PW-1:0] byte_idx,
    output scr_mode_t     mode_now,
    output cell_region_t  region
);

    localparam logic [PW-1:0] PARK_POS = PW'(CELL_BYTES);
    localparam logic [PW-1:0] HEC_POS  = PW'(HDR_BYTES);

    logic [PW-1:0] pos_q;
    scr_mode_t     mode_q;

    // Position, mode and region of the byte currently on the input
    always_comb begin
        byte_idx = in_soc ? '0 : pos_q;
        if (in_soc)                mode_now = resolve_mode(sss_en, dss_en);
        else if (pos_q == PARK_POS) mode_now = MODE_BYP;
        else                       mode_now = mode_q;
        if (byte_idx == PARK_POS)     region = REG_OUT;
        else if (byte_idx < HEC_POS)  region = REG_HDR;
        else if (byte_idx == HEC_POS) region = REG_HEC;
        else                          region = REG_PAY;
    end

    // Advance the position and hold the cell mode on each accepted byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q  <= PARK_POS;
            mode_q <= MODE_BYP;
        end else if (in_valid) begin
            pos_q  <= (region == REG_OUT) ? PARK_POS : byte_idx + 1'b1;
            mode_q <= mode_now;
        end
    end

    p_pos_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= PARK_POS);

    p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_soc && pos_q != PARK_POS) |=> $stable(mode_q));

    p_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_soc && sss_en) |=> (mode_q == MODE_SSS));

    p_no_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(pos_q) && $stable(mode_q)));

endmodule

// File: rtl/scr_sss_engine.sv
// Self-synchronizing scrambler for one byte per clock, MSB first.
// Each output bit is the input bit XOR the scrambled bit LEN bit-times back.
// Assumes the history is cleared only by reset and advances only on 'advance'.
module scr_sss_engine #(
    parameter int DW  = 8,
    parameter int LEN = 43
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);

    logic [LEN-1:0] hist_q;
    logic [LEN-1:0] hist_d;

    // Scramble one byte bit-serially and form the next history
    always_comb begin
        logic [LEN-1:0] h;
        logic           b;
        h = hist_q;
        for (int i = DW - 1; i >= 0; i--) begin
            b       = din[i] ^ h[LEN-1];
            dout[i] = b;
            h       = {h[LEN-2:0], b};
        end
        hist_d = h;
    end

    // Keep the history of sent scrambled bits
    always_ff @(posedge clk) begin
        if (!rst_n)       hist_q <= '0;
        else if (advance) hist_q <= hist_d;
    end

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(hist_q));

endmodule

// File: rtl/scr_dss_engine.sv
// Distributed-sample scrambler mask generator: a free-running Fibonacci
// generator with taps at LEN and TAP, stepped DW times per advanced byte.
// Assumes a nonzero SEED; the mask for the current byte is combinational.
module scr_dss_engine #(
    parameter int             DW   = 8,
    parameter int             LEN  = 31,
    parameter int             TAP  = 28,
    parameter logic [LEN-1:0] SEED = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    output logic [DW-1:0] mask
);

    logic [LEN-1:0] gen_q;
    logic [LEN-1:0] gen_d;

    // Produce the byte mask and the generator state DW steps ahead
    always_comb begin
        logic [LEN-1:0] g;
        logic           fb;
        g = gen_q;
        for (int i = DW - 1; i >= 0; i--) begin
            mask[i] = g[LEN-1];
            fb      = g[LEN-1] ^ g[TAP-1];
            g       = {g[LEN-2:0], fb};
        end
        gen_d = g;
    end

    // Step the generator on each byte of a distributed-sample cell
    always_ff @(posedge clk) begin
        if (!rst_n)       gen_q <= SEED;
        else if (advance) gen_q <= gen_d;
    end

    p_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        gen_q != '0);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(gen_q));

endmodule

// File: rtl/scr_hec_gen.sv
// Header check generator: CRC over the header bytes, MSB first, zero start,
// with a fixed coset added on output.
// Assumes 'clear' marks the first header byte and 'update' each header byte.
module scr_hec_gen #(
    parameter int            DW    = 8,
    parameter logic [DW-1:0] POLY  = 8'h07,
    parameter logic [DW-1:0] COSET = 8'h55
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          update,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] hec
);

    logic [DW-1:0] crc_q;
    logic [DW-1:0] crc_d;

    // Fold one byte into the running remainder
    always_comb begin
        logic [DW-1:0] c;
        logic          fb;
        c = clear ? '0 : crc_q;
        for (int i = DW - 1; i >= 0; i--) begin
            fb = c[DW-1] ^ din[i];
            c  = {c[DW-2:0], 1'b0};
            if (fb) c = c ^ POLY;
        end
        crc_d = c;
    end

    // Present the check byte with its coset applied
    always_comb hec = crc_q ^ COSET;

    // Hold the remainder between header bytes
    always_ff @(posedge clk) begin
        if (!rst_n)      crc_q <= '0;
        else if (update) crc_q <= crc_d;
    end

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !update |=> $stable(crc_q));

endmodule

// File: rtl/atm_cell_scrambler.sv
// ATM cell transmit scrambler. Selects per cell between bypass, a
// self-synchronizing payload scrambler and a distributed-sample whole-cell
// scrambler with header check regeneration; output is registered once.
// Assumes byte-wide cells with in_soc on position 0 and no backpressure.
module atm_cell_scrambler
    import atm_scr_pkg::*;
#(
    parameter int CELL_BYTES = 53,
    parameter int HDR_BYTES  = 4,
    parameter int DW         = 8,
    parameter int SSS_LEN    = 43,
    parameter int DSS_LEN    = 31,
    parameter int DSS_TAP    = 28,
    localparam int PW        = $clog2(CELL_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_soc,
    input  logic [DW-1:0] in_data,
    input  logic          sss_en,
    input  logic          dss_en,
    output logic          out_valid,
    output logic          out_soc,
    output logic [DW-1:0] out_data
);

    logic [PW-1:0] byte_idx;
    scr_mode_t     mode_now;
    cell_region_t  region;
    logic          sss_adv;
    logic          dss_adv;
    logic          hec_upd;
    logic [DW-1:0] sss_dout;
    logic [DW-1:0] dss_mask;
    logic [DW-1:0] dss_byte;
    logic [DW-1:0] hec_byte;
    logic [DW-1:0] data_next;

    scr_cell_tracker #(
        .CELL_BYTES (CELL_BYTES),
        .HDR_BYTES  (HDR_BYTES)
    ) u_tracker (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_soc   (in_soc),
        .sss_en   (sss_en),
        .dss_en   (dss_en),
        .byte_idx (byte_idx),
        .mode_now (mode_now),
        .region   (region)
    );

    // Engine strobes for the accepted byte
    always_comb begin
        sss_adv  = in_valid && (mode_now == MODE_SSS) && (region == REG_PAY);
        dss_adv  = in_valid && (mode_now == MODE_DSS);
        hec_upd  = dss_adv && (region == REG_HDR);
        dss_byte = in_data ^ dss_mask;
    end

    scr_sss_engine #(
        .DW  (DW),
        .LEN (SSS_LEN)
    ) u_sss (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (sss_adv),
        .din     (in_data),
        .dout    (sss_dout)
    );

    scr_dss_engine #(
        .DW   (DW),
        .LEN  (DSS_LEN),
        .TAP  (DSS_TAP),
        .SEED ({DSS_LEN{1'b1}})
    ) u_dss (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (dss_adv),
        .mask    (dss_mask)
    );

    scr_hec_gen #(
        .DW    (DW),
        .POLY  (DW'(8'h07)),
        .COSET (DW'(8'h55))
    ) u_hec (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (byte_idx == '0),
        .update (hec_upd),
        .din    (dss_byte),
        .hec    (hec_byte)
    );

    // Pick the outgoing byte by mode and region
    always_comb begin
        case (mode_now)
            MODE_SSS: data_next = (region == REG_PAY) ? sss_dout : in_data;
            MODE_DSS: data_next = (region == REG_HEC) ? hec_byte : dss_byte;
            default:  data_next = in_data;
        endcase
    end

    // Register the output stream once
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_soc   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            out_soc   <= in_valid && in_soc;
            if (in_valid) out_data <= data_next;
        end
    end

    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_soc_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_soc) |=> out_soc);

    p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_now == MODE_BYP) |=> (out_data == $past(in_data)));

    p_sss_hdr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_now == MODE_SSS && region != REG_PAY)
            |=> (out_data == $past(in_data)));

    p_dss_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_now != MODE_DSS) |=> $stable(u_dss.gen_q));

endmodule

// File: tb/atm_cell_scrambler_tb_top.sv
// Self-checking bench: random and directed cells compared with a bench model.
module atm_cell_scrambler_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CELL       = 53;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic       in_soc;
    logic [7:0] in_data;
    logic       sss_en;
    logic       dss_en;
    logic       out_valid;
    logic       out_soc;
    logic [7:0] out_data;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    // Bench model state
    logic [42:0] m_sss;
    logic [30:0] m_dss;
    logic [7:0]  m_crc;
    int          m_pos;
    int          m_mode;

    always #(CLK_PERIOD / 2) clk = ~clk;

    atm_cell_scrambler dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_soc    (in_soc),
        .in_data   (in_data),
        .sss_en    (sss_en),
        .dss_en    (dss_en),
        .out_valid (out_valid),
        .out_soc   (out_soc),
        .out_data  (out_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] crc8_step(input logic [7:0] c_in, input logic [7:0] d);
        logic [7:0] c;
        logic       fb;
        c = c_in;
        for (int i = 7; i >= 0; i--) begin
            fb = c[7] ^ d[i];
            c  = {c[6:0], 1'b0};
            if (fb) c = c ^ 8'h07;
        end
        return c;
    endfunction

    task automatic model_reset();
        m_sss  = '0;
        m_dss  = '1;
        m_crc  = '0;
        m_pos  = CELL;
        m_mode = 0;
    endtask

    // Expected output for one accepted byte, with the requirement it tests
    task automatic model_byte(input bit soc, input logic [7:0] d, input bit se,
                              input bit de, output logic [7:0] exp, output string tag);
        int         idx;
        int         mode;
        logic [7:0] mask;
        logic       b;
        logic       fb;
        idx = soc ? 0 : m_pos;
        if (soc)              mode = se ? 1 : (de ? 2 : 0);
        else if (m_pos == CELL) mode = 0;
        else                  mode = m_mode;
        exp = d;
        if (idx == CELL) tag = "R10";
        else if (mode == 0) tag = "R3";
        else if (mode == 1) begin
            if (idx < 5) tag = "R4";
            else begin
                tag = "R5";
                for (int i = 7; i >= 0; i--) begin
                    b      = d[i] ^ m_sss[42];
                    exp[i] = b;
                    m_sss  = {m_sss[41:0], b};
                end
            end
        end else begin
            for (int i = 7; i >= 0; i--) begin
                mask[i] = m_dss[30];
                fb      = m_dss[30] ^ m_dss[27];
                m_dss   = {m_dss[29:0], fb};
            end
            if (idx == 0) m_crc = '0;
            if (idx < 4) begin
                tag   = "R7";
                exp   = d ^ mask;
                m_crc = crc8_step(m_crc, exp);
            end else if (idx == 4) begin
                tag = "R8";
                exp = m_crc ^ 8'h55;
            end else begin
                tag = "R7";
                exp = d ^ mask;
            end
        end
        m_pos  = (idx == CELL) ? CELL : idx + 1;
        m_mode = mode;
    endtask

    // Present one byte at a falling edge and check it at the next one
    task automatic send(input bit soc, input logic [7:0] d, input bit se,
                        input bit de, input string tag_ovr);
        logic [7:0] exp;
        string      tag;
        in_valid = 1'b1;
        in_soc   = soc;
        in_data  = d;
        sss_en   = se;
        dss_en   = de;
        model_byte(soc, d, se, de, exp, tag);
        if (tag_ovr != "") tag = tag_ovr;
        @(negedge clk);
        check(out_valid == 1'b1, "R1", "out_valid", out_valid, 1);
        check(out_soc == soc, "R1", "out_soc", out_soc, soc);
        check(out_data == exp, tag, "out_data", out_data, exp);
    endtask

    // One idle cycle with garbage on the other inputs (R12)
    task automatic gap();
        in_valid = 1'b0;
        in_soc   = 1'($urandom_range(1, 0));
        in_data  = 8'($urandom);
        sss_en   = 1'($urandom_range(1, 0));
        dss_en   = 1'($urandom_range(1, 0));
        @(negedge clk);
        check(out_valid == 1'b0, "R12", "out_valid idle", out_valid, 0);
        check(out_soc == 1'b0, "R12", "out_soc idle", out_soc, 0);
    endtask

    task automatic send_cell(input bit se, input bit de, input string tag_ovr,
                             input int nbytes, input bit flip_en, input int gap_pct);
        for (int j = 0; j < nbytes; j++) begin
            while (int'($urandom_range(99, 0)) < gap_pct) gap();
            if (flip_en && j > 0)
                send(1'b0, 8'($urandom), 1'($urandom_range(1, 0)),
                     1'($urandom_range(1, 0)), tag_ovr);
            else
                send(j == 0, 8'($urandom), se, de, tag_ovr);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5C2A_71E3));
        model_reset();
        rst_n    = 1'b0;
        in_valid = 1'b1;
        in_soc   = 1'b1;
        in_data  = 8'hA5;
        sss_en   = 1'b1;
        dss_en   = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R11", "out_valid in reset", out_valid, 0);
        check(out_soc == 1'b0, "R11", "out_soc in reset", out_soc, 0);
        check(out_data == 8'h00, "R11", "out_data in reset", out_data, 0);
        in_valid = 1'b0;
        in_soc   = 1'b0;
        rst_n    = 1'b1;
        @(negedge clk);

        // Bytes before any start of cell pass through (R10)
        for (int k = 0; k < 4; k++) send(1'b0, 8'($urandom), 1'b1, 1'b1, "R10");

        // Directed cells
        send_cell(1'b0, 1'b0, "", CELL, 1'b0, 0);   // bypass R3
        send_cell(1'b1, 1'b0, "", CELL, 1'b0, 0);   // SSS R4 R5
        send_cell(1'b1, 1'b0, "", CELL, 1'b0, 10);  // SSS history carried (R6)
        send_cell(1'b0, 1'b1, "", CELL, 1'b0, 0);   // DSS R7 R8
        send_cell(1'b1, 1'b0, "R6", CELL, 1'b0, 0); // SSS after DSS: history intact
        send_cell(1'b1, 1'b1, "R9", CELL, 1'b0, 0); // both enabled -> SSS
        send_cell(1'b0, 1'b1, "R2", CELL, 1'b1, 0); // enables flip mid-cell
        send_cell(1'b1, 1'b0, "R2", CELL, 1'b1, 0);
        send_cell(1'b0, 1'b0, "R2", CELL, 1'b1, 0);
        for (int k = 0; k < 5; k++) send(1'b0, 8'($urandom), 1'b0, 1'b1, "R10");
        send_cell(1'b0, 1'b1, "R10", 20, 1'b0, 0);  // truncated, then restart
        send_cell(1'b0, 1'b1, "", CELL, 1'b0, 0);
        send_cell(1'b1, 1'b0, "R6", CELL, 1'b0, 0);

        // Random cells
        for (int c = 0; c < 200; c++) begin
            int n;
            n = (int'($urandom_range(9, 0)) == 0) ? int'($urandom_range(CELL - 1, 1)) : CELL;
            send_cell(1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)), "",
                      n, 1'(int'($urandom_range(7, 0)) == 0), 15);
            if (int'($urandom_range(7, 0)) == 0)
                for (int k = 0; k < int'($urandom_range(4, 1)); k++)
                    send(1'b0, 8'($urandom), 1'b1, 1'b1, "");
        end

        gap();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule